// File: doc/BRIEF.md
# Binary32 Compare to Condition Flags

This block compares two single-precision floating-point words, called the first operand (d) and the second operand (m). It reports the outcome as four condition flags, negative (N), zero (Z), carry (C) and overflow (V), plus an invalid-operation flag. It never unpacks the operands. The exponent and mantissa fields are examined only to spot NaNs. Ordering is decided on the raw sign-magnitude patterns.

A request is presented with `in_valid`, together with two controls:
- `quiet_signals` makes quiet NaNs raise the invalid flag.
- `zero_mode` substitutes an all-zero word (+0) for the second operand.

Operands and controls are captured on the request cycle. The flags appear in the next cycle together with `out_valid`. The reset input asserts asynchronously and is released through a two-stage synchronizer.

Top module: `fcmp_flags`

## Requirements
- R1: While `out_valid` is low, including after reset, all five flag outputs are 0.
- R2: `out_valid` is 1 in exactly the cycle that follows a clock edge at which `in_valid` was 1, and 0 otherwise.
- R3: Bit-identical ordered operands give N=0, Z=1, C=1, V=0.
- R4: Two zeros compare equal whatever their signs (+0 equals -0), giving Z=1, C=1.
- R5: Non-NaN operands of opposite sign, not both zero: a negative d gives N=1 only (less), and a negative m gives C=1 only (greater).
- R6: Non-NaN operands with the same sign (bit 31) and different patterns: the low 31 bits are compared as unsigned integers. For positive operands a smaller d gives N=1 (less), otherwise C=1 (greater). For negative operands the outcome is inverted.
- R7: A word is a NaN when bits 30..23 are all ones and bits 22..0 are nonzero; infinities are not NaNs. If either operand is a NaN the result is unordered: C=1, V=1, N=0, Z=0.
- R8: The invalid flag is 1 only for an unordered result. It is raised when a NaN operand has bit 22 clear (signalling), or when any NaN is present and `quiet_signals` is 1.
- R9: With `zero_mode` at 1 the second operand is +0 and `op_m` has no effect, even if it holds a NaN.
- R10: While `out_valid` is 1, {N,Z,C,V} is exactly one of 1000 (less), 0110 (equal), 0010 (greater), 0011 (unordered).
- R11: Operands and controls are taken only at the `in_valid` edge; input changes after that edge leave the presented flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe; captures operands and controls |
| op_d | input | 32 | First operand |
| op_m | input | 32 | Second operand |
| zero_mode | input | 1 | Compare d against +0 instead of op_m |
| quiet_signals | input | 1 | Quiet NaNs also raise invalid |
| out_valid | output | 1 | Flags valid this cycle |
| flag_n | output | 1 | Less-than flag |
| flag_z | output | 1 | Equal flag |
| flag_c | output | 1 | Greater, equal or unordered flag |
| flag_v | output | 1 | Unordered flag |
| flag_invalid | output | 1 | Invalid-operation flag |

## Verification
The bench builds the block with its default field widths: an 8-bit exponent and a 23-bit mantissa. Every stimulus is therefore a genuine binary32 encoding: signed zeros, a smallest denormal, the largest finite value beside infinity, and quiet and signalling NaNs in either operand position. These widths bring within reach the boundary between infinity and NaN, and the quiet bit that separates signalling from quiet NaNs. After each capture the bench scrambles all inputs, so every result also shows that the captured values are held.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2
  } rel_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
    logic inv;
  } cmp_flags_t;

endpackage

// File: rtl/fcmp_nan_detect.sv
module fcmp_nan_detect #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] word,
  input  logic         quiet_signals,
  output logic         is_nan,
  output logic         raise_inv
);
  logic [EXP_W-1:0] exp_f;
  logic [MAN_W-1:0] man_f;
  logic             quiet_bit;

  always_comb begin
    exp_f     = word[W-2 -: EXP_W];
    man_f     = word[MAN_W-1:0];
    quiet_bit = man_f[MAN_W-1];
    is_nan    = (&exp_f) && (|man_f);
    // a signalling NaN always raises; a quiet one only when asked to
    raise_inv = is_nan && (quiet_signals || !quiet_bit);
  end
endmodule

// File: rtl/fcmp_magnitude.sv
module fcmp_magnitude
  import fcmp_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output rel_e         rel
);
  logic both_zero;
  logic sign_diff;
  logic mag_lt;

  always_comb begin
    both_zero = ((a[W-2:0] | b[W-2:0]) == '0);
    sign_diff = a[W-1] ^ b[W-1];
    mag_lt    = (a[W-2:0] < b[W-2:0]);
    if ((a == b) || both_zero) begin
      rel = REL_EQ;
    end else if (sign_diff) begin
      rel = a[W-1] ? REL_LT : REL_GT;
    end else if (a[W-1] ^ mag_lt) begin
      rel = REL_LT;
    end else begin
      rel = REL_GT;
    end
  end
endmodule

// File: rtl/fcmp_flag_encode.sv
module fcmp_flag_encode
  import fcmp_pkg::*;
(
  input  logic       valid,
  input  logic       unordered,
  input  logic       raise_in,
  input  rel_e       rel,
  output cmp_flags_t flags
);
  always_comb begin
    flags = '0;
    if (valid) begin
      if (unordered) begin
        flags.c   = 1'b1;
        flags.v   = 1'b1;
        flags.inv = raise_in;
      end else begin
        unique case (rel)
          REL_LT:  flags.n = 1'b1;
          REL_EQ:  begin flags.z = 1'b1; flags.c = 1'b1; end
          default: flags.c = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/fcmp_flags.sv
module fcmp_flags
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] op_d,
  input  logic [W-1:0] op_m,
  input  logic         zero_mode,
  input  logic         quiet_signals,
  output logic         out_valid,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_invalid
);
  localparam int NOPND = 2;

  // reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // capture stage
  logic [W-1:0] d_q, d_d, m_q, m_d;
  logic         qs_q, qs_d, vld_q, vld_d;

  always_comb begin
    d_d   = d_q;
    m_d   = m_q;
    qs_d  = qs_q;
    vld_d = in_valid;
    if (in_valid) begin
      d_d  = op_d;
      m_d  = zero_mode ? '0 : op_m;
      qs_d = quiet_signals;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      d_q   <= '0;
      m_q   <= '0;
      qs_q  <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      d_q   <= d_d;
      m_q   <= m_d;
      qs_q  <= qs_d;
      vld_q <= vld_d;
    end
  end

  // classification of both operands
  logic [NOPND-1:0][W-1:0] opnd;
  logic [NOPND-1:0]        nan_v;
  logic [NOPND-1:0]        inv_v;

  assign opnd[0] = d_q;
  assign opnd[1] = m_q;

  for (genvar gi = 0; gi < NOPND; gi++) begin : g_cls
    fcmp_nan_detect #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_nan (
      .word          (opnd[gi]),
      .quiet_signals (qs_q),
      .is_nan        (nan_v[gi]),
      .raise_inv     (inv_v[gi])
    );
  end

  rel_e       rel_ord;
  cmp_flags_t flags;

  fcmp_magnitude #(.W(W)) u_mag (
    .a   (d_q),
    .b   (m_q),
    .rel (rel_ord)
  );

  fcmp_flag_encode u_enc (
    .valid     (vld_q),
    .unordered (|nan_v),
    .raise_in  (|inv_v),
    .rel       (rel_ord),
    .flags     (flags)
  );

  assign out_valid    = vld_q;
  assign flag_n       = flags.n;
  assign flag_z       = flags.z;
  assign flag_c       = flags.c;
  assign flag_v       = flags.v;
  assign flag_invalid = flags.inv;

  // checks
  assert_idle_clear_R1: assert property (@(posedge clk) disable iff (!rst_int_n)
    !out_valid |-> ({flag_n, flag_z, flag_c, flag_v, flag_invalid} == 5'b0));

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid);

  assert_no_spurious_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> !out_valid);

  assert_signed_zero_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !zero_mode && op_d[W-2:0] == '0 && op_m[W-2:0] == '0)
      |=> (flag_z && flag_c && !flag_v));

  assert_invalid_unordered_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    flag_invalid |-> (flag_c && flag_v && !flag_n && !flag_z));

  assert_zero_mode_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && zero_mode && op_d[W-2:0] == '0) |=> (flag_z && !flag_v));

  assert_legal_code_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> ({flag_n, flag_z, flag_c, flag_v} inside {4'b1000, 4'b0110, 4'b0010, 4'b0011}));

endmodule

// File: tb/sim_fcmp_flags.sv
module sim_fcmp_flags;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_d, op_m;
  logic        zero_mode, quiet_signals;
  logic        out_valid, flag_n, flag_z, flag_c, flag_v, flag_invalid;

  int checks = 0;
  int fails  = 0;

  localparam logic [3:0] LT = 4'b1000;
  localparam logic [3:0] EQ = 4'b0110;
  localparam logic [3:0] GT = 4'b0010;
  localparam logic [3:0] UN = 4'b0011;

  always #(CLK_PERIOD/2) clk = ~clk;

  fcmp_flags u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .op_d(op_d), .op_m(op_m), .zero_mode(zero_mode),
    .quiet_signals(quiet_signals), .out_valid(out_valid),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c),
    .flag_v(flag_v), .flag_invalid(flag_invalid)
  );

  task automatic check(string req, logic [5:0] act, logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got {vld,N,Z,C,V,inv}=%b expected %b", req, act, exp);
    end
  endtask

  // one request; inputs are scrambled after capture (R11) before sampling
  task automatic do_cmp(string req, logic [31:0] d, logic [31:0] m,
                        logic zm, logic qs, logic [3:0] nzcv, logic inv);
    @(negedge clk);
    op_d = d; op_m = m; zero_mode = zm; quiet_signals = qs; in_valid = 1'b1;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    op_d = 32'h7F80_0001; op_m = 32'h7F80_0001;
    zero_mode = ~zm; quiet_signals = ~qs;
    @(negedge clk);
    check(req, {out_valid, flag_n, flag_z, flag_c, flag_v, flag_invalid},
          {1'b1, nzcv, inv});
  endtask

  task automatic test_reset();
    check("R1 reset", {out_valid, flag_n, flag_z, flag_c, flag_v, flag_invalid}, 6'b0);
  endtask

  task automatic test_latency();
    do_cmp("R2 first", 32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, EQ, 1'b0);
    @(negedge clk);
    check("R2 idle R1", {out_valid, flag_n, flag_z, flag_c, flag_v, flag_invalid}, 6'b0);
  endtask

  task automatic test_ordered();
    do_cmp("R3 equal",       32'h3F80_0000, 32'h3F80_0000, 1'b0, 1'b0, EQ, 1'b0);
    do_cmp("R4 +0 vs -0",    32'h0000_0000, 32'h8000_0000, 1'b0, 1'b0, EQ, 1'b0);
    do_cmp("R4 -0 vs +0",    32'h8000_0000, 32'h0000_0000, 1'b0, 1'b0, EQ, 1'b0);
    do_cmp("R5 -1 vs 1",     32'hBF80_0000, 32'h3F80_0000, 1'b0, 1'b0, LT, 1'b0);
    do_cmp("R5 1 vs -0.5",   32'h3F80_0000, 32'hBF00_0000, 1'b0, 1'b0, GT, 1'b0);
    do_cmp("R6 1 vs 2",      32'h3F80_0000, 32'h4000_0000, 1'b0, 1'b0, LT, 1'b0);
    do_cmp("R6 2 vs 1",      32'h4000_0000, 32'h3F80_0000, 1'b0, 1'b0, GT, 1'b0);
    do_cmp("R6 -1 vs -2",    32'hBF80_0000, 32'hC000_0000, 1'b0, 1'b0, GT, 1'b0);
    do_cmp("R6 -2 vs -1",    32'hC000_0000, 32'hBF80_0000, 1'b0, 1'b0, LT, 1'b0);
    do_cmp("R7 inf vs max",  32'h7F80_0000, 32'h7F7F_FFFF, 1'b0, 1'b0, GT, 1'b0);
    do_cmp("R7 -inf vs -inf",32'hFF80_0000, 32'hFF80_0000, 1'b0, 1'b0, EQ, 1'b0);
  endtask

  task automatic test_nan();
    do_cmp("R7 qNaN d",      32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b0, UN, 1'b0);
    do_cmp("R8 qNaN signal", 32'h7FC0_0000, 32'h3F80_0000, 1'b0, 1'b1, UN, 1'b1);
    do_cmp("R8 sNaN d",      32'h7F80_0001, 32'h3F80_0000, 1'b0, 1'b0, UN, 1'b1);
    do_cmp("R8 sNaN m",      32'h3F80_0000, 32'hFF80_0001, 1'b0, 1'b0, UN, 1'b1);
    do_cmp("R7 qNaN m",      32'h3F80_0000, 32'hFFC0_0001, 1'b0, 1'b0, UN, 1'b0);
  endtask

  task automatic test_zero_mode();
    do_cmp("R9 -1 vs zero",  32'hBF80_0000, 32'h7FC0_0000, 1'b1, 1'b1, LT, 1'b0);
    do_cmp("R9 -0 vs zero",  32'h8000_0000, 32'h3F80_0000, 1'b1, 1'b0, EQ, 1'b0);
    do_cmp("R9 denorm",      32'h0000_0001, 32'hFF80_0001, 1'b1, 1'b0, GT, 1'b0);
    do_cmp("R9 R8 sNaN d",   32'hFF80_0001, 32'h0000_0000, 1'b1, 1'b0, UN, 1'b1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks + 1, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; op_d = '0; op_m = '0;
    zero_mode = 1'b0; quiet_signals = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    test_reset();
    test_latency();
    test_ordered();
    test_nan();
    test_zero_mode();
    // R10 and R11 are covered by every do_cmp call above
    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule